// File: doc/BRIEF.md
# PHY Control Register Write Sequencer

This block performs one indirect write into a register inside a serial-link PHY. The PHY cannot be written directly. A 32-bit control word carries a 16-bit payload and three strobes, and a single acknowledge bit comes back inside a 32-bit status word. A write needs three full handshakes. First the register address is captured, then the data value, then a write strobe commits the data. In each handshake the strobe is raised, the block waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall.

The host side gives a one-cycle start pulse together with the address and the data. The block reports a one-cycle done pulse, or a sticky error flag when the PHY fails to answer. Every acknowledge wait has its own bounded budget, counted in millisecond ticks from a clock prescaler. If any wait runs out, the whole sequence is aborted. After the last handshake the block holds off for a settle interval before it reports done.

Top module: `phyw_seq`

## Requirements
- R1: After reset `phy_ctl` is zero and `busy`, `done` and `err` are low. While `busy` is low, `phy_ctl` stays zero.
- R2: In `phy_ctl`, bits 15:0 carry the payload. Bit 16 is the address-capture strobe, bit 17 the data-capture strobe and bit 18 the write strobe. At most one strobe is set at a time, and bits 31:19 are always zero.
- R3: Address handshake: the address is driven alone for one cycle. Then bit 16 is added until acknowledge high is seen. Then the address is driven alone (bit 16 cleared, payload kept) until acknowledge low is seen.
- R4: Data handshake: the same pattern as R3, with the data value as payload and bit 17 as strobe. It follows the address handshake.
- R5: Write handshake: bit 18 is driven with a zero payload until acknowledge high is seen. Then `phy_ctl` is all zero until acknowledge low is seen. The PHY thus receives the captured address and data exactly once per sequence.
- R6: The acknowledge is bit 18 of `phy_stat`, and every other status bit is ignored. It passes through a two-flop synchronizer, so a strobe changes exactly three cycles after the acknowledge edge appears at the port.
- R7: Each acknowledge wait may last `WAIT_MS` millisecond ticks (one tick every `CLK_KHZ` cycles), counted from the cycle its strobe word first appears. If the budget runs out, the block drops `busy`, sets `err`, returns `phy_ctl` to zero and gives no `done`.
- R8: After the final acknowledge-low, the block waits `SETTLE_MS` ticks. It then pulses `done` for exactly one cycle as `busy` falls.
- R9: A start pulse while `busy` is high is ignored. The running sequence keeps its address and data.
- R10: `err` stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a write |
| reg_addr | input | 16 | PHY register address, sampled on an accepted start |
| reg_data | input | 16 | Value to write, sampled on an accepted start |
| phy_stat | input | 32 | PHY status word; bit 18 is the acknowledge |
| phy_ctl | output | 32 | Control word toward the PHY |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Sticky timeout flag |

## Verification
A wrong step counter or wrong state shows on `phy_ctl` within one cycle, as a missing pre-drive cycle, a strobe on the wrong bit or a payload that was not released. The PHY model then captures the wrong address or data by the next acknowledge edge. A wrong synchronizer depth moves each strobe release off its three-cycle distance from the acknowledge edge. A broken prescaler or budget counter moves the error flag, or the done pulse, off the cycle predicted from the tick period. This becomes visible at the end of the affected wait or settle interval.

// File: rtl/phyw_pkg.sv
package phyw_pkg;

  localparam int CTL_W    = 32;
  localparam int PAY_W    = 16;
  localparam int CAPA_BIT = 16;
  localparam int CAPD_BIT = 17;
  localparam int WR_BIT   = 18;
  localparam int ACK_BIT  = 18;
  localparam int STEP_W   = 3;

  typedef logic [STEP_W-1:0] phyw_step_t;
  localparam phyw_step_t STEP_LAST = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_SETTLE
  } phyw_state_e;

  // Control word for a handshake step; pre selects the payload-only cycle.
  function automatic logic [CTL_W-1:0] phyw_word(phyw_step_t s, logic pre,
                                                 logic [PAY_W-1:0] a,
                                                 logic [PAY_W-1:0] d);
    logic [CTL_W-1:0] w;
    w = '0;
    case (s)
      3'd0: begin w[PAY_W-1:0] = a; w[CAPA_BIT] = !pre; end
      3'd1: w[PAY_W-1:0] = a;
      3'd2: begin w[PAY_W-1:0] = d; w[CAPD_BIT] = !pre; end
      3'd3: w[PAY_W-1:0] = d;
      3'd4: w[WR_BIT] = 1'b1;
      default: w = '0;
    endcase
    return w;
  endfunction

  // Even steps wait for acknowledge high, odd steps for low.
  function automatic logic phyw_expect_hi(phyw_step_t s);
    return ~s[0];
  endfunction

  // Steps that start with a payload-only cycle.
  function automatic logic phyw_has_pre(phyw_step_t s);
    return (s == 3'd0) || (s == 3'd2);
  endfunction

endpackage

// File: rtl/phyw_sync.sv
module phyw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/phyw_tick.sv
module phyw_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phyw_budget.sv
module phyw_budget #(
  parameter int MS_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [MS_W-1:0] limit,
  output logic            expire
);
  logic [MS_W-1:0] ms;

  assign expire = tick && ((ms + MS_W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    ms <= '0;
    else if (clr)  ms <= '0;
    else if (tick) ms <= ms + 1'b1;
  end
endmodule

// File: rtl/phyw_seq.sv
module phyw_seq
  import phyw_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int WAIT_MS     = 100,
  parameter int SETTLE_MS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAY_W-1:0] reg_addr,
  input  logic [PAY_W-1:0] reg_data,
  input  logic [CTL_W-1:0] phy_stat,
  output logic [CTL_W-1:0] phy_ctl,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int MAX_MS = (WAIT_MS > SETTLE_MS) ? WAIT_MS : SETTLE_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  phyw_state_e      state, state_n;
  phyw_step_t       step, step_n;
  logic [PAY_W-1:0] addr_q, data_q;

  // Named internal events
  logic ack_s, ack_match, ms_tick, expire;
  logic take, load, timeout_ev, finish_ev;
  logic [MS_W-1:0] limit_sel;

  logic unused_stat;
  assign unused_stat = ^{phy_stat[CTL_W-1:ACK_BIT+1], phy_stat[ACK_BIT-1:0]};

  phyw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(phy_stat[ACK_BIT]), .q(ack_s)
  );

  phyw_tick #(.DIV(CLK_KHZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(load), .tick(ms_tick)
  );

  assign limit_sel = (state == ST_SETTLE) ? MS_W'(SETTLE_MS) : MS_W'(WAIT_MS);

  phyw_budget #(.MS_W(MS_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(load), .tick(ms_tick),
    .limit(limit_sel), .expire(expire)
  );

  assign ack_match = (ack_s == phyw_expect_hi(step));

  always_comb begin
    state_n    = state;
    step_n     = step;
    take       = 1'b0;
    load       = 1'b0;
    timeout_ev = 1'b0;
    finish_ev  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_PRE;
          step_n  = '0;
          take    = 1'b1;
        end
      end
      ST_PRE: begin
        state_n = ST_WAIT;
        load    = 1'b1;
      end
      ST_WAIT: begin
        if (ack_match) begin
          if (step == STEP_LAST) begin
            state_n = ST_SETTLE;
            load    = 1'b1;
          end else begin
            step_n = step + 3'd1;
            if (phyw_has_pre(step_n)) state_n = ST_PRE;
            else                      load    = 1'b1;
          end
        end else if (expire) begin
          state_n    = ST_IDLE;
          timeout_ev = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (expire) begin
          state_n   = ST_IDLE;
          finish_ev = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step   <= '0;
      addr_q <= '0;
      data_q <= '0;
      err    <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= state_n;
      step  <= step_n;
      done  <= finish_ev;
      if (take) begin
        addr_q <= reg_addr;
        data_q <= reg_data;
        err    <= 1'b0;
      end else if (timeout_ev) begin
        err <= 1'b1;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign phy_ctl = (state == ST_PRE || state == ST_WAIT)
                   ? phyw_word(step, state == ST_PRE, addr_q, data_q)
                   : '0;
endmodule

// File: rtl/phyw_seq_chk.sv
module phyw_seq_chk
  import phyw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [CTL_W-1:0] phy_ctl,
  input logic [PAY_W-1:0] addr_q,
  input logic             timeout_ev,
  input logic             finish_ev
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phy_ctl == '0));

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctl[WR_BIT:CAPA_BIT]));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctl[CTL_W-1:WR_BIT+1] == '0);

  // R5
  wr_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctl[WR_BIT] |-> (phy_ctl[PAY_W-1:0] == '0));

  // R7
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (err && !busy && !done && phy_ctl == '0));

  // R8
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> (done && !busy && !err));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  end_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done != err));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy && $stable(addr_q)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> err);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!err && busy));
endmodule

bind phyw_seq phyw_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .phy_ctl(phy_ctl), .addr_q(addr_q),
  .timeout_ev(timeout_ev), .finish_ev(finish_ev)
);

// File: tb/phyw_seq_tb.sv
`timescale 1ns/1ps
module phyw_seq_tb_top;
  localparam int K = 4;   // cycles per tick
  localparam int W = 20;  // wait budget in ticks
  localparam int S = 3;   // settle in ticks
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] reg_addr = '0, reg_data = '0;
  logic [31:0] phy_stat = '0;
  logic [31:0] phy_ctl;
  logic busy, done, err;

  always #4 clk = ~clk;

  phyw_seq #(.CLK_KHZ(K), .WAIT_MS(W), .SETTLE_MS(S), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_addr(reg_addr),
    .reg_data(reg_data), .phy_stat(phy_stat), .phy_ctl(phy_ctl),
    .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] clk_ovrd(input logic [1:0] pre);
    return 16'h8000 | (16'(pre) << 13) | (16'd6 << 8) | (16'd2 << 6) | 16'd7;
  endfunction

  // PHY model and monitor, all on the falling edge
  int cyc = 0;
  logic ack_m = 1'b0;
  int cnt_m = 0;
  int dly_hi = 0, dly_lo = 0;
  logic [15:0] cap_a = '0, cap_d = '0, wr_a = '0, wr_d = '0;
  int wr_cnt = 0, pre_bad = 0, shape_bad = 0, done_n = 0;
  int stb_rise_cyc = 0, ack_fall_cyc = 0, ack_rise_cyc = 0, rel_gap = 0;
  int err_cyc = 0, done_cyc = 0;
  logic [31:0] prev_ctl = '0;
  logic err_prev = 1'b0;

  always @(negedge clk) begin
    logic want;
    logic [31:0] junk;
    cyc++;
    junk = $urandom;
    if (!rst_n) begin
      ack_m = 1'b0; cnt_m = 0; prev_ctl = '0; err_prev = 1'b0;
    end else begin
      want = |phy_ctl[18:16];
      if (phy_ctl[31:19] != 0 || $countones(phy_ctl[18:16]) > 1 ||
          (phy_ctl[18] && phy_ctl[15:0] != 0))
        shape_bad++;
      if ((phy_ctl[16] && !prev_ctl[16]) || (phy_ctl[17] && !prev_ctl[17]))
        if (prev_ctl != {16'h0, phy_ctl[15:0]}) pre_bad++;
      if ((!phy_ctl[16] && prev_ctl[16]) || (!phy_ctl[17] && prev_ctl[17])) begin
        if (phy_ctl != {16'h0, prev_ctl[15:0]}) pre_bad++;
        rel_gap = cyc - ack_rise_cyc;
      end
      if (want && !(|prev_ctl[18:16])) stb_rise_cyc = cyc;
      if (want != ack_m) begin
        if (cnt_m >= (want ? dly_hi : dly_lo)) begin
          ack_m = want; cnt_m = 0;
          if (want) begin
            ack_rise_cyc = cyc;
            if (phy_ctl[16]) cap_a = phy_ctl[15:0];
            if (phy_ctl[17]) cap_d = phy_ctl[15:0];
            if (phy_ctl[18]) begin wr_cnt++; wr_a = cap_a; wr_d = cap_d; end
          end else ack_fall_cyc = cyc;
        end else cnt_m++;
      end else cnt_m = 0;
      prev_ctl = phy_ctl;
      if (done) begin done_n++; done_cyc = cyc; end
      if (err && !err_prev) err_cyc = cyc;
      err_prev = err;
    end
    phy_stat = {junk[31:19], ack_m, junk[17:0]};
    if (cyc > WDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic kick(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; reg_addr = a; reg_data = d;
    @(negedge clk);
    start = 1'b0; reg_addr = 16'($urandom); reg_data = 16'($urandom);
    chk(busy && !err, "R10", "accepted start clears err", {busy, err}, 2'b10);
  endtask

  task automatic run_ok(input logic [15:0] a, input logic [15:0] d,
                        input int dh, input int dl, input bit poke);
    int w0, dn0, pb0, sb0;
    dly_hi = dh; dly_lo = dl;
    w0 = wr_cnt; dn0 = done_n; pb0 = pre_bad; sb0 = shape_bad;
    kick(a, d);
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; reg_addr = ~a; reg_data = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
    chk(done_n == dn0 + 1 && !err, "R8", "one done, no err", done_n - dn0, 1);
    chk(cap_a == a, "R3", "captured address", cap_a, a);
    chk(cap_d == d, "R4", "captured data", cap_d, d);
    chk(wr_cnt == w0 + 1 && wr_a == a && wr_d == d, "R5", "single commit",
        {wr_a, wr_d}, {a, d});
    chk(pre_bad == pb0, "R3", "pre-drive and release words", pre_bad - pb0, 0);
    chk(shape_bad == sb0, "R2", "control word layout", shape_bad - sb0, 0);
    chk(rel_gap == 3, "R6", "ack edge to strobe release", rel_gap, 3);
    chk(done_cyc - ack_fall_cyc >= S*K + 2 && done_cyc - ack_fall_cyc <= S*K + 4,
        "R8", "settle interval", done_cyc - ack_fall_cyc, S*K + 3);
    chk(phy_ctl == 0 && !busy, "R1", "idle word after done", phy_ctl, 0);
    if (poke) chk(cap_a == a && wr_d == d, "R9", "start while busy ignored",
                  {wr_a, wr_d}, {a, d});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(phy_ctl == 0 && !busy && !done && !err, "R1", "reset state",
        {phy_ctl, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(phy_ctl == 0 && !busy, "R1", "idle after reset", phy_ctl, 0);

    // Directed: clock-override register, fast PHY
    run_ok(16'h0012, clk_ovrd(2'b01), 0, 0, 1'b0);
    run_ok(16'h0012, clk_ovrd(2'b00), 5, 2, 1'b0);
    run_ok(16'hFFFF, 16'h0000, 1, 1, 1'b0);
    // Near the wait budget
    run_ok(16'h1234, 16'hABCD, 70, 70, 1'b0);
    // Start while busy
    run_ok(16'h5A5A, 16'hC3C3, 3, 3, 1'b1);

    // R7: timeout waiting for ack high in the address handshake
    begin
      int w0, dn0;
      w0 = wr_cnt; dn0 = done_n;
      dly_hi = 100000; dly_lo = 0;
      kick(16'h0BAD, 16'h0DAD);
      wait_idle();
      chk(err && !busy && phy_ctl == 0, "R7", "abort on ack-high timeout",
          {err, busy}, 2'b10);
      chk(done_n == dn0 && wr_cnt == w0, "R7", "no done, no commit",
          done_n - dn0, 0);
      chk(err_cyc - stb_rise_cyc >= W*K - 1 && err_cyc - stb_rise_cyc <= W*K + 1,
          "R7", "timeout budget", err_cyc - stb_rise_cyc, W*K);
      repeat (50) @(negedge clk);
      chk(err, "R10", "err stays set", err, 1);
    end

    // R7: timeout waiting for ack low in the address handshake
    begin
      int w0;
      w0 = wr_cnt;
      cap_d = 16'hEEEE;
      dly_hi = 2; dly_lo = 100000;
      kick(16'h0777, 16'h0888);
      wait_idle();
      chk(err && !busy && phy_ctl == 0, "R7", "abort on ack-low timeout",
          {err, busy}, 2'b10);
      chk(cap_a == 16'h0777 && cap_d == 16'hEEEE && wr_cnt == w0, "R7",
          "sequence stops before data", cap_d, 16'hEEEE);
      dly_lo = 0;
      repeat (10) @(negedge clk);
    end

    // R10: recovery after error
    run_ok(16'h0042, 16'h4242, 2, 2, 1'b0);

    // Random mix
    for (int i = 0; i < 20; i++) begin
      run_ok(16'($urandom), 16'($urandom), int'($urandom_range(0, 30)),
             int'($urandom_range(0, 30)), 1'($urandom_range(0, 3) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
  end
endmodule